// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Controller

This block collects interrupt requests from a fixed set of peripheral sources, holds each one as a pending bit, and decides whether the processor should take one now. Each source has a 3-bit priority level, loaded through a one-entry-per-cycle write port. Each cycle the block picks the most urgent eligible pending source. A source is eligible when its level is strictly above the processor's current 3-bit priority level and, unless it belongs to the non-maskable set, the global enable input is high.

When a source wins, the block registers a one-cycle acknowledge together with the source index and the byte address of its vector. Vector entries are 4 bytes wide and sit after a 32-bit table base. Source index `i` carries interrupt number `FIRST_NUM + i`. In the same cycle the winner's pending bit is cleared. Stacking the processor context and fetching the vector are done by the consumer of the acknowledge.

Top module: `intc_accept`

## Requirements
- R1: A pending source is acknowledged only when its level is strictly greater than `ipl_i` and either `irq_en_i` is 1 or the source is non-maskable.
- R2: With `ipl_i` = 7 no source is acknowledged, and a source whose level is 0 is never acknowledged.
- R3: With `ipl_i` = N, a source at level N stays pending and unacknowledged, while a source at level N+1 is accepted.
- R4: Sources flagged in the `NMI_MASK` parameter (default: only index 7) are accepted with `irq_en_i` = 0, provided their level exceeds `ipl_i`.
- R5: Among eligible pending sources, the highest level wins, and a tie at the same level goes to the lowest index.
- R6: A request sampled at clock edge k sets the pending bit, and `ack_o` is high for exactly the one cycle after edge k+1. `ack_src_o` and `ack_vec_o` are valid while `ack_o` is high.
- R7: `ack_vec_o` equals `tbl_base_i + 4*(FIRST_NUM + ack_src_o)`, with `FIRST_NUM` = 50 by default. Index 7 (interrupt 57) therefore maps to base + 228.
- R8: The winner's pending bit clears at the acknowledge edge. If the same source requests again at that edge, the bit stays set and the source is acknowledged again on the next cycle.
- R9: A request that is not eligible stays pending and is acknowledged as soon as the enable or level conditions allow it.
- R10: Levels reset to 0. A level write changes only the addressed source's level, and it changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request strobes, one per source |
| lvl_we_i | input | 1 | Level write enable |
| lvl_idx_i | input | IDX_W | Source index to write |
| lvl_wdata_i | input | 3 | Level value to write |
| irq_en_i | input | 1 | Global maskable-interrupt enable |
| ipl_i | input | 3 | Processor priority level |
| tbl_base_i | input | ADDR_W | Vector table base address |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_src_o | output | IDX_W | Index of the accepted source |
| ack_vec_o | output | ADDR_W | Byte address of the accepted source's vector |

## Verification
Assertions check on every cycle that any winner is pending, above the processor level and enabled or non-maskable. They also check that no eligible source outranks the winner, that a processor level of 7 is never followed by an acknowledge, and that the registered vector matches the registered source. Further assertions check that an unrefreshed winner's pending bit is gone one cycle later and that a level write touches only its target. Only the bench scenarios can show the behaviour over a sequence of cycles: the exact latency from request to acknowledge, pending bits that survive until a later change in enable or level, the order of back-to-back acknowledges, and the second acknowledge produced by a request that arrives at the acknowledge edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_MAX = '1;
endpackage

// File: rtl/intc_lvl_regs.sv
module intc_lvl_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  lvl_t                        wdata_i,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.lvl[idx_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R10: a write lands in the addressed entry
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> lvl_o[$past(idx_i)] == $past(wdata_i));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_keep
        // R10: other entries keep their value
        a_r10_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && (idx_i != IDX_W'(g))) |=> $stable(lvl_o[g]));
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] NMI_MASK = '0,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    input  logic                          irq_en_i,
    input  lvl_t                          ipl_i,
    output logic                          win_vld_o,
    output logic [IDX_W-1:0]              win_idx_o,
    output lvl_t                          win_lvl_o
);
    logic [NUM_SRC-1:0] elig;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            elig[i] = pend_i[i] && (lvl_i[i] > ipl_i) && (irq_en_i || NMI_MASK[i]);
    end

    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_vld_o || lvl_i[i] > win_lvl_o)) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_vecgen.sv
module intc_vecgen #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 3,
    parameter int FIRST_NUM = 50
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] vec_o
);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(FIRST_NUM);

    logic [ADDR_W-1:0] num;

    always_comb begin
        num   = FIRST + ADDR_W'(idx_i);
        vec_o = base_i + (num << 2);
    end
endmodule

// File: rtl/intc_accept.sv
module intc_accept
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int ADDR_W    = 32,
    parameter int FIRST_NUM = 50,
    parameter logic [NUM_SRC-1:0] NMI_MASK = NUM_SRC'(1) << (NUM_SRC - 1),
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               lvl_we_i,
    input  logic [IDX_W-1:0]   lvl_idx_i,
    input  logic [LVL_W-1:0]   lvl_wdata_i,
    input  logic               irq_en_i,
    input  logic [LVL_W-1:0]   ipl_i,
    input  logic [ADDR_W-1:0]  tbl_base_i,
    output logic               ack_o,
    output logic [IDX_W-1:0]   ack_src_o,
    output logic [ADDR_W-1:0]  ack_vec_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               ack;
        logic [IDX_W-1:0]   src;
        logic [ADDR_W-1:0]  vec;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    logic [ADDR_W-1:0]  win_vec;
    logic [NUM_SRC-1:0] clr;

    intc_lvl_regs #(.NUM_SRC(NUM_SRC)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lvl_we_i),
        .idx_i   (lvl_idx_i),
        .wdata_i (lvl_wdata_i),
        .lvl_o   (lvl)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .NMI_MASK(NMI_MASK)) u_arb (
        .pend_i    (st_q.pend),
        .lvl_i     (lvl),
        .irq_en_i  (irq_en_i),
        .ipl_i     (ipl_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    intc_vecgen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIRST_NUM(FIRST_NUM)) u_vec (
        .base_i (tbl_base_i),
        .idx_i  (win_idx),
        .vec_o  (win_vec)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (win_vld) clr[win_idx] = 1'b1;
        st_d.pend = (st_q.pend & ~clr) | req_i;
        st_d.ack  = win_vld;
        if (win_vld) begin
            st_d.src = win_idx;
            st_d.vec = win_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o     = st_q.ack;
    assign ack_src_o = st_q.src;
    assign ack_vec_o = st_q.vec;

    // R1: a winner is pending, above the processor level, and enabled or non-maskable
    a_r1_win_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (st_q.pend[win_idx] && (win_lvl > ipl_i) && (irq_en_i || NMI_MASK[win_idx])));

    // R2: processor level 7 blocks the following acknowledge
    a_r2_ipl7_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_i == LVL_MAX) |=> !ack_o);

    // R5: no eligible source outranks the winner
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
        a_r5_no_better: assert property (@(posedge clk) disable iff (!rst_n)
            (win_vld && st_q.pend[g] && (lvl[g] > ipl_i) && (irq_en_i || NMI_MASK[g]))
            |-> ((lvl[g] < win_lvl) || ((lvl[g] == win_lvl) && (IDX_W'(g) >= win_idx))));
    end

    // R7: registered vector matches registered source
    a_r7_vec_match: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vec_o == $past(tbl_base_i) + ((ADDR_W'(FIRST_NUM) + ADDR_W'(ack_src_o)) << 2));

    // R8: an unrefreshed winner drops its pending bit
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && !req_i[win_idx]) |=> !st_q.pend[$past(win_idx)]);
endmodule

// File: tb/intc_accept_bench.sv
module intc_accept_bench;
    localparam int NUM_SRC = 8;
    localparam int IDX_W   = 3;
    localparam int FIRSTN  = 50;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] req = '0;
    logic               we = 1'b0;
    logic [IDX_W-1:0]   widx = '0;
    logic [2:0]         wdat = '0;
    logic               ien = 1'b0;
    logic [2:0]         ipl = '0;
    logic [31:0]        base = 32'h0000_1000;
    logic               ack;
    logic [IDX_W-1:0]   src;
    logic [31:0]        vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intc_accept u_intc_accept (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_we_i(we), .lvl_idx_i(widx),
        .lvl_wdata_i(wdat), .irq_en_i(ien), .ipl_i(ipl), .tbl_base_i(base),
        .ack_o(ack), .ack_src_o(src), .ack_vec_o(vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic exp_ack(input string tag, input bit present, input int s);
        chk(ack == present, tag, 32'(ack), 32'(present));
        if (present) begin
            chk(src == IDX_W'(s), tag, 32'(src), 32'(s));
            chk(vec == base + 32'(4 * (FIRSTN + s)), {tag, " R7 vec"}, vec, base + 32'(4 * (FIRSTN + s)));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; we = 1'b0; ien = 1'b0; ipl = '0; base = 32'h0000_1000;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic set_lvl(input int i, input int v);
        we = 1'b1; widx = IDX_W'(i); wdat = 3'(v);
        step();
        we = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] m);
        req = m;
        step();
        req = '0;
    endtask

    task automatic t_reset();
        do_reset();
        exp_ack("R10 reset no ack", 0, 0);
        ien = 1'b1; ipl = 3'd0;
        pulse(8'h04);
        for (int k = 0; k < 3; k++) begin step(); exp_ack("R2 level 0 never", 0, 0); end
    endtask

    task automatic t_basic();
        do_reset();
        set_lvl(3, 4); ien = 1'b1; ipl = 3'd2;
        pulse(8'h08);
        exp_ack("R6 no early ack", 0, 0);
        step(); exp_ack("R1 accept", 1, 3);
        step(); exp_ack("R6 single pulse", 0, 0);
        step(); exp_ack("R8 cleared", 0, 0);
    endtask

    task automatic t_boundary();
        do_reset();
        set_lvl(1, 3); ien = 1'b1; ipl = 3'd3;
        pulse(8'h02);
        for (int k = 0; k < 3; k++) begin step(); exp_ack("R3 equal level rejected", 0, 0); end
        ipl = 3'd2;
        step(); exp_ack("R3 level N+1 accepted", 1, 1);
    endtask

    task automatic t_enable();
        do_reset();
        set_lvl(4, 5); ien = 1'b0; ipl = 3'd0;
        pulse(8'h10);
        for (int k = 0; k < 3; k++) begin step(); exp_ack("R1 disabled", 0, 0); end
        ien = 1'b1;
        step(); exp_ack("R9 held then accepted", 1, 4);
    endtask

    task automatic t_ipl7();
        do_reset();
        set_lvl(5, 7); ien = 1'b1; ipl = 3'd7;
        pulse(8'h20);
        for (int k = 0; k < 3; k++) begin step(); exp_ack("R2 ipl 7 blocks", 0, 0); end
        ipl = 3'd6;
        step(); exp_ack("R9 accepted at ipl 6", 1, 5);
    endtask

    task automatic t_nmi();
        do_reset();
        set_lvl(7, 2); ien = 1'b0; ipl = 3'd2;
        pulse(8'h80);
        step(); exp_ack("R4 nmi still level gated", 0, 0);
        ipl = 3'd1;
        step(); exp_ack("R4 nmi bypasses enable", 1, 7);
        chk(vec == base + 32'd228, "R7 number 57 offset 228", vec, base + 32'd228);
    endtask

    task automatic t_rank();
        do_reset();
        set_lvl(0, 3); set_lvl(2, 5); set_lvl(6, 5);
        ien = 1'b0; ipl = 3'd0;
        pulse(8'h45);
        ien = 1'b1;
        step(); exp_ack("R5 highest, low index", 1, 2);
        step(); exp_ack("R5 tie second", 1, 6);
        step(); exp_ack("R5 lowest level last", 1, 0);
        step(); exp_ack("R5 drained", 0, 0);
    endtask

    task automatic t_rereq();
        do_reset();
        set_lvl(3, 4); ien = 1'b1; ipl = 3'd0;
        req = 8'h08;
        step(); step();
        req = '0;
        exp_ack("R8 first ack", 1, 3);
        step(); exp_ack("R8 re-request acked again", 1, 3);
        step(); exp_ack("R8 then clear", 0, 0);
    endtask

    task automatic t_indep();
        do_reset();
        set_lvl(1, 6); set_lvl(2, 2); set_lvl(2, 1);
        ien = 1'b1; ipl = 3'd5;
        pulse(8'h06);
        step(); exp_ack("R10 untouched level 6 kept", 1, 1);
        step(); exp_ack("R10 rewritten level 1 blocked", 0, 0);
        ipl = 3'd0;
        step(); exp_ack("R10 pending kept across writes", 1, 2);
    endtask

    task automatic t_base();
        do_reset();
        base = 32'h8000_0000;
        set_lvl(0, 1); ien = 1'b1; ipl = 3'd0;
        pulse(8'h01);
        step(); exp_ack("R7 alternate base", 1, 0);
        chk(vec == 32'h8000_00C8, "R7 base plus 200", vec, 32'h8000_00C8);
    endtask

    initial begin
        step();
        t_reset();
        t_basic();
        t_boundary();
        t_enable();
        t_ipl7();
        t_nmi();
        t_rank();
        t_rereq();
        t_indep();
        t_base();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule